// File: doc/BRIEF.md
# Pipelined Binary-to-Decimal Digit Converter

This block turns a 16-bit unsigned binary sample into five packed decimal (BCD) digits. It uses the shift-and-add-3 method. Each correct-then-shift step has its own register stage, so the logic between any two flops is a single step: four small compare-and-add cells followed by a one-bit shift. Because no step needs correction in the first three shifts, the sample enters the first stage already moved left by three bits. That leaves thirteen registered steps.

A sample is taken on any clock where `inValid` is high, and back-to-back samples are allowed. A valid bit follows each sample down the pipe and appears on `outValid` together with the digits. It fits both a sample stream that arrives on every fourth clock and a continuous stream. Synchronous reset drops any samples still inside the pipe. The data flops carry no reset. They load only when the stage before them holds a valid sample, so the output digits keep the last result between results.

Top module: `bcdPipeConv`

## Requirements
- R1: When `outValid` is high, `outBcd` holds the decimal value of the sample with the ones digit in bits [3:0], tens in [7:4], hundreds in [11:8], thousands in [15:12] and ten-thousands in [18:16]. This holds for every input from 0 to 65535.
- R2: A sample presented with `inValid` high in clock cycle c appears with `outValid` high in cycle c+13, and in no other cycle.
- R3: Samples on consecutive clocks are all converted. They leave on consecutive clocks in the order they entered.
- R4: `outValid` is high only in cycles that match an accepted sample. Sparse input, such as one sample every fourth clock, gives an output pulse pattern with the same spacing.
- R5: Every digit in the output is at most 9, and the ten-thousands digit is at most 6.
- R6: While `outValid` is low, `outBcd` keeps the last result unchanged. `inData` has no effect when `inValid` is low, and it has no effect during reset.
- R7: While `rst` is high, `outValid` is low. Samples accepted before reset never produce an output after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all stage valid bits |
| inValid | input | 1 | Marks a sample on `inData` to convert |
| inData | input | 16 | Unsigned binary sample |
| outValid | output | 1 | High for one cycle per converted sample |
| outBcd | output | 19 | Packed decimal digits of the sample |

## Verification
A table of fixed values covers the points where digit carries happen: 0, 9, 10, 99, 100, 4095, 9999, 10000, 32768, 50000 and 65535. These show whether each add-3 correction fires at the right threshold and whether carries reach the narrow top digit. A long burst of random values on consecutive clocks tests the pipe at full rate and the ordering of results. The same values sent one every fourth clock show whether the valid bits stay tied to their data when the pipe has gaps. Idle stretches with random data on the input, and a reset while the pipe is full, test that the output holds and that samples in flight are dropped.

// File: rtl/bcdPipe_pkg.sv
package bcdPipe_pkg;

  // Binary input width and the number of leading shifts that need no correction.
  localparam int PKG_BIN_W       = 16;
  localparam int PKG_PRE_SHIFT   = 3;
  // Full 4-bit digits that get the add-3 check, and the width of the narrow top digit.
  localparam int PKG_FULL_DIGITS = 4;
  localparam int PKG_TOP_W       = 3;

  localparam int PKG_BCD_W  = PKG_FULL_DIGITS * 4 + PKG_TOP_W;
  localparam int PKG_WORK_W = PKG_BIN_W + PKG_BCD_W;
  localparam int PKG_STEPS  = PKG_BIN_W - PKG_PRE_SHIFT;

  // Strobes from the valid tracker to the datapath.
  typedef struct packed {
    logic [PKG_STEPS-1:0] stepEn;   // load enable of each step register
    logic                 outValid; // last step holds a fresh result
  } bcdCtrl_t;

endpackage

// File: rtl/bcdPipeStep.sv
// One correction step: add 3 to each full digit field that is above 4.
module bcdPipeStep #(
  parameter int BIN_W       = 16,
  parameter int FULL_DIGITS = 4,
  parameter int WORK_W      = 35
) (
  input  logic [WORK_W-1:0] workIn,
  output logic [WORK_W-1:0] workOut
);

  always_comb begin
    workOut = workIn;
    for (int d = 0; d < FULL_DIGITS; d++) begin
      if (workIn[BIN_W + 4*d +: 4] > 4'd4) begin
        workOut[BIN_W + 4*d +: 4] = workIn[BIN_W + 4*d +: 4] + 4'd3;
      end
    end
  end

endmodule

// File: rtl/bcdPipeCtrl.sv
// Valid tracker: one bit per step register.
module bcdPipeCtrl
  import bcdPipe_pkg::*;
#(
  parameter int NUM_STEPS = PKG_STEPS
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output bcdCtrl_t ctrlS
);

  logic [NUM_STEPS-1:0] stageVld;
  logic [NUM_STEPS-1:0] nextVld;

  assign nextVld = {stageVld[NUM_STEPS-2:0], inValid};

  always_ff @(posedge clk) begin
    if (rst) begin
      stageVld <= '0;
    end else begin
      stageVld <= nextVld;
    end
  end

  // Data registers are held during reset so the last result stays put.
  always_comb begin
    ctrlS.stepEn   = nextVld & {NUM_STEPS{~rst}};
    ctrlS.outValid = stageVld[NUM_STEPS-1];
  end

  AST_INPUT_ENTERS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> stageVld[0]); // R2

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stageVld == '0)); // R7

  for (genvar k = 0; k < NUM_STEPS - 1; k++) begin : gVldChk
    AST_VALID_MOVES: assert property (@(posedge clk) disable iff (rst)
      stageVld[k] |=> stageVld[k+1]); // R3
    AST_VALID_NO_GHOST: assert property (@(posedge clk) disable iff (rst)
      !stageVld[k] |=> !stageVld[k+1]); // R4
  end

endmodule

// File: rtl/bcdPipeData.sv
// Datapath: pre-shifted load followed by one registered correct-and-shift per step.
module bcdPipeData
  import bcdPipe_pkg::*;
#(
  parameter int BIN_W       = PKG_BIN_W,
  parameter int PRE_SHIFT   = PKG_PRE_SHIFT,
  parameter int FULL_DIGITS = PKG_FULL_DIGITS,
  parameter int TOP_W       = PKG_TOP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  bcdCtrl_t            ctrlS,
  input  logic [BIN_W-1:0]    inData,
  output logic [FULL_DIGITS*4+TOP_W-1:0] outBcd
);

  localparam int BCD_W     = FULL_DIGITS * 4 + TOP_W;
  localparam int WORK_W    = BIN_W + BCD_W;
  localparam int NUM_STEPS = BIN_W - PRE_SHIFT;
  localparam int HEAD_W    = WORK_W - BIN_W - PRE_SHIFT;
  localparam int TOP_MAX   = ((2 ** BIN_W) - 1) / (10 ** FULL_DIGITS);

  logic [WORK_W-1:0] stepIn  [NUM_STEPS];
  logic [WORK_W-1:0] corrOut [NUM_STEPS];
  logic [WORK_W-1:0] stageQ  [NUM_STEPS];

  // The first shifts can never need a correction, so they cost nothing.
  assign stepIn[0] = {{HEAD_W{1'b0}}, inData, {PRE_SHIFT{1'b0}}};

  for (genvar k = 0; k < NUM_STEPS; k++) begin : gStep
    if (k > 0) begin : gLink
      assign stepIn[k] = stageQ[k-1];
    end

    bcdPipeStep #(
      .BIN_W      (BIN_W),
      .FULL_DIGITS(FULL_DIGITS),
      .WORK_W     (WORK_W)
    ) step_i (
      .workIn (stepIn[k]),
      .workOut(corrOut[k])
    );

    always_ff @(posedge clk) begin
      if (ctrlS.stepEn[k]) begin
        stageQ[k] <= {corrOut[k][WORK_W-2:0], 1'b0};
      end
    end

    AST_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ctrlS.stepEn[k] |-> !corrOut[k][WORK_W-1]); // R1

    for (genvar d = 0; d < FULL_DIGITS; d++) begin : gDig
      AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ctrlS.stepEn[k] |=> (stageQ[k][BIN_W + 4*d +: 4] <= 4'd9)); // R5
    end
  end

  assign outBcd = stageQ[NUM_STEPS-1][WORK_W-1 -: BCD_W];

  AST_BIN_DRAINED: assert property (@(posedge clk) disable iff (rst)
    ctrlS.outValid |-> (stageQ[NUM_STEPS-1][BIN_W-1:0] == '0)); // R1

  AST_TOP_DIGIT: assert property (@(posedge clk) disable iff (rst)
    ctrlS.outValid |-> (int'(outBcd[BCD_W-1 -: TOP_W]) <= TOP_MAX)); // R5

endmodule

// File: rtl/bcdPipeConv.sv
module bcdPipeConv
  import bcdPipe_pkg::*;
#(
  parameter int BIN_W       = PKG_BIN_W,
  parameter int PRE_SHIFT   = PKG_PRE_SHIFT,
  parameter int FULL_DIGITS = PKG_FULL_DIGITS,
  parameter int TOP_W       = PKG_TOP_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           inValid,
  input  logic [BIN_W-1:0]               inData,
  output logic                           outValid,
  output logic [FULL_DIGITS*4+TOP_W-1:0] outBcd
);

  localparam int NUM_STEPS = BIN_W - PRE_SHIFT;

  bcdCtrl_t ctrlS;

  bcdPipeCtrl #(
    .NUM_STEPS(NUM_STEPS)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .ctrlS  (ctrlS)
  );

  bcdPipeData #(
    .BIN_W      (BIN_W),
    .PRE_SHIFT  (PRE_SHIFT),
    .FULL_DIGITS(FULL_DIGITS),
    .TOP_W      (TOP_W)
  ) data_i (
    .clk   (clk),
    .rst   (rst),
    .ctrlS (ctrlS),
    .inData(inData),
    .outBcd(outBcd)
  );

  assign outValid = ctrlS.outValid;

  AST_RESULT_HOLDS: assert property (@(posedge clk)
    !ctrlS.stepEn[NUM_STEPS-1] |=> $stable(outBcd)); // R6

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R7

endmodule

// File: tb/bcdPipeConv_tb_top.sv
module bcdPipeConv_tb_top;

  localparam int LAT = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [18:0] outBcd;

  bcdPipeConv dut_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outBcd  (outBcd)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [18:0] expQ[$];
  int          tQ[$];
  logic        monEn = 1'b0;
  logic        haveLast = 1'b0;
  logic [18:0] lastOut = '0;

  // input value, expected packed digits
  localparam logic [34:0] VEC [12] = '{
    {16'd0,     19'h00000}, {16'd9,     19'h00009}, {16'd10,    19'h00010},
    {16'd4095,  19'h04095}, {16'd9999,  19'h09999}, {16'd10000, 19'h10000},
    {16'd65535, 19'h65535}, {16'd1234,  19'h01234}, {16'd50000, 19'h50000},
    {16'd99,    19'h00099}, {16'd100,   19'h00100}, {16'd32768, 19'h32768}
  };

  function automatic logic [18:0] refBcd(input int v);
    return {3'(v / 10000), 4'((v / 1000) % 10), 4'((v / 100) % 10),
            4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [15:0] v, input logic [18:0] e);
    @(negedge clk);
    inValid = 1'b1;
    inData  = v;
    expQ.push_back(e);
    tQ.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = 16'($urandom);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (monEn) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4 spurious outValid", 32'(outValid), 32'd0);
        end else begin
          logic [18:0] e;
          int t;
          e = expQ.pop_front();
          t = tQ.pop_front();
          chk(outBcd == e, "R1 digits", 32'(outBcd), 32'(e));
          chk((cyc - t) == LAT, "R2 latency", 32'(cyc - t), 32'(LAT));
          chk((outBcd[3:0] <= 9) && (outBcd[7:4] <= 9) && (outBcd[11:8] <= 9) &&
              (outBcd[15:12] <= 9) && (outBcd[18:16] <= 6),
              "R5 digit range", 32'(outBcd), 32'(e));
          lastOut  <= outBcd;
          haveLast <= 1'b1;
        end
      end else if (haveLast) begin
        chk(outBcd == lastOut, "R6 hold", 32'(outBcd), 32'(lastOut));
      end
    end
  end

  logic done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R7 reset outValid", 32'(outValid), 32'd0);
    rst = 1'b0;
    monEn = 1'b1;

    // Table walk, back-to-back (R1, R3)
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][34:19], VEC[i][18:0]);
    end
    idle(20);

    // Random burst on consecutive clocks (R3)
    for (int i = 0; i < 120; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      send(v, refBcd(int'(v)));
    end
    idle(20);

    // Sparse stream, one sample every fourth clock (R4)
    for (int i = 0; i < 40; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      send(v, refBcd(int'(v)));
      idle(3);
    end
    idle(20);

    // Idle with changing data: output must hold (R6)
    idle(30);

    // Reset with the pipe partly full: samples are dropped (R7)
    for (int i = 0; i < 5; i++) begin
      send(16'(1000 + i), refBcd(1000 + i));
    end
    idle(3);
    @(negedge clk);
    rst = 1'b1;
    inData = 16'hBEEF;
    expQ.delete();
    tQ.delete();
    @(negedge clk);
    chk(outValid == 1'b0, "R7 outValid in reset", 32'(outValid), 32'd0);
    @(negedge clk);
    chk(outValid == 1'b0, "R7 outValid in reset", 32'(outValid), 32'd0);
    rst = 1'b0;
    idle(25);

    // Corner values once more after reset (R1)
    send(16'd65535, 19'h65535);
    send(16'd0,     19'h00000);
    send(16'd10000, 19'h10000);
    idle(20);

    chk(expQ.size() == 0, "R2 all results delivered", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule